// File: doc/BRIEF.md
# Ternary Lookup Memory with Encoded Match Listing

This block is a small associative store. Each slot keeps a stored word together with a per-bit compare mask. A mask bit of 1 makes that bit take part in the comparison. A mask bit of 0 turns it into a wildcard that agrees with either key value, so one slot can stand for a whole family of words. Slots are loaded while the system runs, through a write port that carries a slot index, a word and a mask. A synchronous clear empties every slot at once.

A lookup applies a key to every occupied slot in parallel. The block raises a found indication, then lists the index of every agreeing slot as a binary number. It gives one index per clock, lowest first, and tags the final one. If no slot agrees, it shows a single miss cycle instead. The block takes one request at a time. It shows that it is ready when it is idle, and write or clear requests are taken only while it is ready. A requester holds its write request until the block accepts it.

Top module: `tcam_enc`

## Requirements
- R1: After reset, ready is 1, found, addr_valid and last are 0, and every slot is empty, so a lookup reports a miss.
- R2: A write is taken on a rising edge where wr_en and ready are both 1. It stores wr_data and wr_care in slot wr_addr and marks the slot occupied. A later write to the same slot replaces the earlier contents.
- R3: An occupied slot agrees with the key when every bit whose wr_care bit was 1 equals the corresponding key bit. Bits whose wr_care bit was 0 agree with both 0 and 1.
- R4: A lookup is accepted on a rising edge where srch_valid and ready are both 1. Its first result cycle begins after the second rising edge that follows. Ready is 0 from acceptance until the edge after the cycle that has last=1.
- R5: When one or more slots agree, the block gives one result cycle per agreeing slot. In every such cycle found and addr_valid are 1, and match_addr carries the slot index as an unsigned binary number. The indices come out in strictly ascending order, and last is 1 only in the final cycle.
- R6: When no slot agrees, the block gives exactly one result cycle, with found=0, addr_valid=0 and last=1.
- R7: An empty slot never agrees. A clear (clr while ready) empties all slots. When clr and wr_en are both taken on the same edge, the clear wins and the slot stays empty.
- R8: A write taken on the same edge as a lookup is applied before that lookup compares, so the lookup sees the new contents.
- R9: A wr_en pulse while ready is 0 has no effect on any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty all slots (taken when ready) |
| wr_en | input | 1 | Write request (taken when ready) |
| wr_addr | input | AW | Slot index to write |
| wr_data | input | WIDTH | Stored word |
| wr_care | input | WIDTH | Compare mask, 1 = bit compared, 0 = wildcard |
| srch_valid | input | 1 | Lookup request (taken when ready) |
| srch_key | input | WIDTH | Lookup key |
| ready | output | 1 | Idle; requests are accepted |
| found | output | 1 | At least one slot agrees (valid in result cycles) |
| addr_valid | output | 1 | match_addr holds an agreeing slot index |
| match_addr | output | AW | Encoded index of an agreeing slot |
| last | output | 1 | Final result cycle of the lookup |

## Verification
Wildcard bits are the first target. A design that compared masked-off bits would turn expected multi-slot hits into misses, or drop slots from the list. Lookups that agree with several scattered slots check the ascending listing and the final-cycle flag. An encoder that repeated an index, skipped one, or set last early shows up as a wrong address or a wrong count of result cycles. Three further cases each tie to a visible wrong result. A slot that was never written or was cleared must stay silent. A clear must beat a write on the same edge, and a write on the same edge as a lookup must reach it. Finally, a write pulse during a busy lookup must be dropped, or a later lookup shows changed contents.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_EMIT} st_e;

  // Ternary compare: only bits with care=1 must be equal.
  function automatic logic tern_hit(input wide_t key, input wide_t val, input wide_t care);
    return ((key ^ val) & care) == '0;
  endfunction

  // Index of the least significant set bit (0 if none).
  function automatic int lowest_idx(input wide_t v);
    int idx;
    idx = 0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Vector with its least significant set bit removed.
  function automatic wide_t drop_lowest(input wide_t v);
    return v & (v - wide_t'(1));
  endfunction

  // True when at most one bit is set.
  function automatic logic single_left(input wide_t v);
    return (v & (v - wide_t'(1))) == '0;
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store
  import tcam_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_fire,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_care,
  input  logic [WIDTH-1:0] key,
  output logic [DEPTH-1:0] match
);
  logic [DEPTH-1:0] occ;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] care_q;
    logic             sel;

    assign sel = wr_fire && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ[g] <= 1'b0;
      end else if (clr_fire) begin
        occ[g] <= 1'b0;
      end else if (sel) begin
        occ[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && !clr_fire) begin
        val_q  <= wr_data;
        care_q <= wr_care;
      end
    end

    assign match[g] = occ[g] && tern_hit(wide_t'(key), wide_t'(val_q), wide_t'(care_q));
  end
endmodule

// File: rtl/tcam_sched.sv
module tcam_sched
  import tcam_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_fire,
  input  logic [WIDTH-1:0] srch_key,
  output logic [WIDTH-1:0] key_q,
  input  logic [DEPTH-1:0] match,
  output logic             ready,
  output logic             found,
  output logic             addr_valid,
  output logic [AW-1:0]    match_addr,
  output logic             last
);
  typedef logic [DEPTH-1:0] pend_t;

  st_e   state;
  pend_t pend;
  logic  hit_q;
  wide_t pend_w;

  assign pend_w = wide_t'(pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pend  <= '0;
      hit_q <= 1'b0;
      key_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (srch_fire) begin
          key_q <= srch_key;
          state <= ST_LOOK;
        end
        ST_LOOK: begin
          pend  <= match;
          hit_q <= |match;
          state <= ST_EMIT;
        end
        ST_EMIT: begin
          pend <= pend_t'(drop_lowest(pend_w));
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready      = (state == ST_IDLE);
  assign found      = (state == ST_EMIT) && hit_q;
  assign addr_valid = (state == ST_EMIT) && (pend != '0);
  assign match_addr = AW'(lowest_idx(pend_w));
  assign last       = (state == ST_EMIT) && (!hit_q || single_left(pend_w));
endmodule

// File: rtl/tcam_enc.sv
module tcam_enc
  import tcam_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_care,
  input  logic             srch_valid,
  input  logic [WIDTH-1:0] srch_key,
  output logic             ready,
  output logic             found,
  output logic             addr_valid,
  output logic [AW-1:0]    match_addr,
  output logic             last
);
  // Named internal events, used by the bound checker.
  logic             clr_fire;
  logic             wr_fire;
  logic             srch_fire;
  logic [WIDTH-1:0] key_q;
  logic [DEPTH-1:0] match;

  assign clr_fire  = clr && ready;
  assign wr_fire   = wr_en && ready;
  assign srch_fire = srch_valid && ready;

  tcam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_fire(clr_fire), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_care(wr_care),
    .key(key_q), .match(match)
  );

  tcam_sched #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_sched (
    .clk(clk), .rst_n(rst_n), .srch_fire(srch_fire), .srch_key(srch_key),
    .key_q(key_q), .match(match), .ready(ready), .found(found),
    .addr_valid(addr_valid), .match_addr(match_addr), .last(last)
  );
endmodule

// File: rtl/tcam_enc_chk.sv
module tcam_enc_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          srch_fire,
  input logic          wr_fire,
  input logic          found,
  input logic          addr_valid,
  input logic [AW-1:0] match_addr,
  input logic          last
);
  // R5: an index is only presented together with found.
  p_addr_needs_found_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> found);

  // R5: listed indices strictly ascend.
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !last) |=> (addr_valid && (match_addr > $past(match_addr))));

  // R6: a miss cycle is always the last one.
  p_miss_is_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !found) |-> !addr_valid);

  // R4: accepted lookup drops ready and reports after two edges.
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srch_fire |=> !ready);
  p_result_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srch_fire |=> ##1 (last || addr_valid));
  p_idle_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> ready);

  // R9: no write is taken while a lookup is in flight.
  p_no_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || last) |-> !wr_fire);

  // R5: the index is always inside the memory.
  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (int'(match_addr) < DEPTH));
endmodule

bind tcam_enc tcam_enc_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .srch_fire(srch_fire),
  .wr_fire(wr_fire), .found(found), .addr_valid(addr_valid),
  .match_addr(match_addr), .last(last)
);

// File: tb/tcam_enc_bench.sv
module tcam_enc_bench;
  localparam int D  = 8;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  wr_care = '0;
  logic          srch_valid = 1'b0;
  logic [W-1:0]  srch_key = '0;
  logic          ready, found, addr_valid, last;
  logic [AW-1:0] match_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_val [D];
  logic [W-1:0] m_care[D];
  bit           m_occ [D];

  always #10 clk = ~clk;

  tcam_enc #(.DEPTH(D), .WIDTH(W)) u_tcam_enc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_care(wr_care), .srch_valid(srch_valid),
    .srch_key(srch_key), .ready(ready), .found(found), .addr_valid(addr_valid),
    .match_addr(match_addr), .last(last)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model slot agreement: every cared bit equal, wildcard bits free.
  function automatic bit model_hit(input logic [W-1:0] key, input int s);
    bit ok;
    ok = m_occ[s];
    for (int b = 0; b < W; b++)
      if (m_care[s][b] && (key[b] !== m_val[s][b])) ok = 1'b0;
    return ok;
  endfunction

  task automatic do_write(input int a, input logic [W-1:0] d, input logic [W-1:0] c, input bit with_clr);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_care = c; clr = with_clr;
    @(negedge clk);
    wr_en = 1'b0; clr = 1'b0;
    if (with_clr) begin
      for (int s = 0; s < D; s++) m_occ[s] = 1'b0;
    end else begin
      m_val[a] = d; m_care[a] = c; m_occ[a] = 1'b1;
    end
  endtask

  // mode 0: plain; 1: write on same edge as lookup; 2: write pulse while busy
  task automatic do_search(input logic [W-1:0] key, input int mode, input int a,
                           input logic [W-1:0] d, input logic [W-1:0] c, input string req);
    int exp_a[D];
    int n;
    @(negedge clk);
    srch_valid = 1'b1; srch_key = key;
    if (mode == 1) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_care = c;
      m_val[a] = d; m_care[a] = c; m_occ[a] = 1'b1;
    end
    n = 0;
    for (int s = 0; s < D; s++) if (model_hit(key, s)) begin exp_a[n] = s; n++; end
    @(negedge clk);
    srch_valid = 1'b0; wr_en = 1'b0;
    chk(ready == 1'b0, "R4", "ready while busy", int'(ready), 0);
    if (mode == 2) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_care = c;
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (n == 0) begin
      chk(found == 1'b0 && addr_valid == 1'b0 && last == 1'b1, req,
          "miss cycle {found,addr_valid,last}", int'({found, addr_valid, last}), 1);
      @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        chk(found && addr_valid, req, "found&addr_valid", int'(found && addr_valid), 1);
        chk(int'(match_addr) == exp_a[i], req, "match_addr", int'(match_addr), exp_a[i]);
        chk(last == (i == n - 1), req, "last", int'(last), int'(i == n - 1));
        @(negedge clk);
      end
    end
    chk(ready == 1'b1, "R4", "ready after last", int'(ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < D; s++) begin m_occ[s] = 1'b0; m_val[s] = '0; m_care[s] = '0; end
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && !found && !addr_valid && !last, "R1", "reset outputs",
        int'({ready, found, addr_valid, last}), 8);
    rst_n = 1'b1;
    // R1: empty after reset -> miss
    do_search(8'h00, 0, 0, '0, '0, "R1");
    // R2/R3 exact entry
    do_write(2, 8'hA5, 8'hFF, 1'b0);
    do_search(8'hA5, 0, 0, '0, '0, "R2");
    do_search(8'hA4, 0, 0, '0, '0, "R3");
    // R2 rewrite replaces
    do_write(2, 8'h3C, 8'hFF, 1'b0);
    do_search(8'hA5, 0, 0, '0, '0, "R2");
    do_search(8'h3C, 0, 0, '0, '0, "R2");
    // R3/R5 wildcards, several scattered matches
    do_write(0, 8'h30, 8'hF0, 1'b0);
    do_write(5, 8'h00, 8'h00, 1'b0);
    do_write(7, 8'h3C, 8'hFC, 1'b0);
    do_search(8'h3C, 0, 0, '0, '0, "R5");
    do_search(8'h3F, 0, 0, '0, '0, "R3");
    // R6 miss with populated memory after removing full wildcard
    do_write(5, 8'hFF, 8'hFF, 1'b0);
    do_search(8'h81, 0, 0, '0, '0, "R6");
    // R9 write pulse while busy is dropped
    do_search(8'h81, 2, 4, 8'h81, 8'hFF, "R9");
    do_search(8'h81, 0, 0, '0, '0, "R9");
    // R8 write on same edge as lookup is seen
    do_search(8'h81, 1, 4, 8'h81, 8'hFF, "R8");
    // R7 clear beats same-edge write; all slots silent
    do_write(6, 8'h3C, 8'h00, 1'b1);
    do_search(8'h3C, 0, 0, '0, '0, "R7");
    do_search(8'h81, 0, 0, '0, '0, "R7");
    // Random mix
    for (int it = 0; it < 120; it++) begin
      int sel;
      int a;
      logic [W-1:0] k;
      sel = int'($urandom % 4);
      a = int'($urandom % D);
      if (sel < 2) begin
        do_write(a, W'($urandom), W'($urandom | $urandom), 1'b0);
      end else begin
        if (sel == 2) k = m_val[a] ^ (W'($urandom) & ~m_care[a]);
        else k = W'($urandom);
        do_search(k, 0, 0, '0, '0, "R5");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule